// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits beside a CPU core. It collects three kinds of request: a parameterized vector of maskable peripheral requests, one active-low maskable external pin, and one active-low non-maskable pin. At each instruction-boundary strobe it decides whether a request should be serviced and, if so, which one. It then reports the chosen source's 8-bit vector identifier. The core uses that identifier to find the handler; fetching the vector from memory and stacking registers happen outside this block.

The block holds the two global mask bits: I gates the maskable sources and X gates the non-maskable pin. On entry they are saved on a small internal LIFO, and a return event restores them. Nested entries therefore unwind in order.

Software has three controls. It can write the mask bits, but X can only be cleared this way. It can set up the external pin through a control register. It can write a promotion byte that lifts one maskable source above every other maskable source.

The control flow is a three-state machine. RUN is the normal state. RUN moves to ACK when a request is accepted, and to RESTORE when a return is honoured. ACK returns to RUN after one cycle. RESTORE returns to RUN after one cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, I=1 and X=1, take_o=0 and vec_o=0x00. The promotion byte holds 0xF2 and the external-pin control holds 0 (pin disabled, level mode).
- R2: Vector identifiers are fixed: 0xF4 for the non-maskable pin, 0xF2 for the external pin, and 0xF0-2k for peripheral k. Among pending maskable sources, the one with the higher identifier wins, unless promotion applies. vec_o changes only on acceptance.
- R3: A write of 0 to cfg_addr_i loads the promotion byte. If the byte equals a maskable source's identifier and that source is pending, that source wins over all other maskable sources. A byte that matches no source leaves the fixed order unchanged.
- R4: A write of 1 to cfg_addr_i loads the pin control. Bit 1 is the enable and bit 0 selects edge mode (0 = level). In level mode with the enable set, the pin requests service for as long as it is low. With the enable clear, the pin never requests.
- R5: In edge mode, a falling edge of the external pin is latched as a request. The latch clears when that source is accepted, so one edge yields one service. If a new edge arrives in the same cycle as the acceptance, the new edge wins.
- R6: While I=1, maskable sources are not accepted. The non-maskable request is accepted regardless of I.
- R7: X=1 after reset blocks the non-maskable pin. A software mask write (sw_we_i) loads I from sw_i_i and ANDs sw_x_i into X, so software can clear X but never set it.
- R8: An acceptance in RUN shows as take_o=1 for exactly the cycle after the strobe, with vec_o holding the winner. A maskable acceptance sets I. A non-maskable acceptance sets both I and X.
- R9: A return event honoured in RUN restores I and X to the values saved by the most recent unreturned entry, in LIFO order. The next cycle is RESTORE.
- R10: Requests are sampled only at a boundary strobe in RUN. A strobe in ACK or RESTORE, or in a cycle where rti_i is high, is ignored. Software mask writes are honoured only in RUN, in a cycle with no acceptance and no honoured return.
- R11: A request that is still pending after a return is accepted at the next boundary strobe.
- R12: When DEPTH entries are outstanding, no request is accepted. A return with no outstanding entry is ignored and leaves I and X unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_req_i | input | NUM_PER | Maskable peripheral requests, level, active high |
| ext_irq_n_i | input | 1 | Maskable external pin, active low |
| nmi_n_i | input | 1 | Non-maskable pin, active low, level |
| boundary_i | input | 1 | Instruction-boundary strobe |
| rti_i | input | 1 | Return-from-interrupt event |
| sw_we_i | input | 1 | Software mask write |
| sw_i_i | input | 1 | New I value for a mask write |
| sw_x_i | input | 1 | X value for a mask write (clear only) |
| cfg_we_i | input | 1 | Configuration write |
| cfg_addr_i | input | 1 | 0 = promotion byte, 1 = pin control |
| cfg_data_i | input | 8 | Configuration write data |
| take_o | output | 1 | High during the ACK cycle |
| vec_o | output | 8 | Vector identifier of the last accepted source |
| mask_i_o | output | 1 | Global maskable mask I |
| mask_x_o | output | 1 | Non-maskable mask X |

## Verification
The assertions assume that boundary_i and rti_i come from a single, well-behaved core. They also assume that any rise of X comes only from an entry or a return. The properties check only relations at the ports and never restrict which input combinations may occur, so the random phase of the stimulus drives strobes, returns, mask writes and configuration writes freely, including in ACK and RESTORE. The directed phase places each strobe one cycle after the previous ACK has finished, so that each nesting step is checked on its own.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ACK,
        ST_RESTORE
    } irqc_state_e;

    localparam logic [7:0] VEC_NMI      = 8'hF4;
    localparam logic [7:0] VEC_EXT      = 8'hF2;
    localparam logic [7:0] VEC_PER_BASE = 8'hF0;

    // identifier of peripheral source k: descending by two from the base
    function automatic logic [7:0] per_vec(input int k);
        return 8'(int'(VEC_PER_BASE) - 2 * k);
    endfunction

endpackage

// File: rtl/irqc_pin_cond.sv
module irqc_pin_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic enable_i,
    input  logic ack_i,
    output logic req_o
);

    logic prev_q;
    logic latch_q;
    logic fall;

    assign fall = prev_q & ~pin_n_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= pin_n_i;
            if (edge_mode_i && fall) begin
                latch_q <= 1'b1;
            end else if (ack_i) begin
                latch_q <= 1'b0;
            end
        end
    end

    assign req_o = enable_i & (edge_mode_i ? latch_q : ~pin_n_i);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_PER = 8
) (
    input  logic               nmi_req_i,
    input  logic               ext_req_i,
    input  logic [NUM_PER-1:0] per_req_i,
    input  logic               mask_ok_i,
    input  logic [7:0]         promo_i,
    output logic               hit_o,
    output logic               nmi_sel_o,
    output logic               ext_sel_o,
    output logic [7:0]         vec_o
);

    localparam int NM = NUM_PER + 1;
    localparam int IW = $clog2(NM);

    logic [NM-1:0] m_req;
    logic [NM-1:0] p_hit;
    logic [7:0]    m_vec [NM];

    logic          f_any, p_any;
    logic [IW-1:0] f_idx, p_idx, sel_idx;

    assign m_req = {per_req_i, ext_req_i};

    // index 0 is the external pin, index k+1 is peripheral k
    genvar j;
    generate
        for (j = 0; j < NM; j++) begin : g_src
            localparam logic [7:0] SRC_VEC = (j == 0) ? VEC_EXT : per_vec(j - 1);
            assign m_vec[j] = SRC_VEC;
            assign p_hit[j] = m_req[j] && (promo_i == SRC_VEC);
        end
    endgenerate

    always_comb begin
        f_any = 1'b0;
        p_any = 1'b0;
        f_idx = '0;
        p_idx = '0;
        for (int k = NM - 1; k >= 0; k--) begin
            if (m_req[k]) begin
                f_any = 1'b1;
                f_idx = IW'(k);
            end
            if (p_hit[k]) begin
                p_any = 1'b1;
                p_idx = IW'(k);
            end
        end
        sel_idx = p_any ? p_idx : f_idx;
    end

    assign nmi_sel_o = nmi_req_i;
    assign hit_o     = nmi_req_i | (mask_ok_i & f_any);
    assign ext_sel_o = ~nmi_req_i & mask_ok_i & f_any & (sel_idx == '0);
    assign vec_o     = nmi_req_i ? VEC_NMI : m_vec[sel_idx];

endmodule

// File: rtl/irqc_mask_stack.sv
module irqc_mask_stack #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic       pop_i,
    input  logic [1:0] din_i,
    output logic [1:0] dout_o,
    output logic       full_o,
    output logic       empty_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = 2 * DEPTH;

    logic [SW-1:0] stk_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
            cnt_q <= '0;
        end else if (push_i && !full_o) begin
            stk_q <= {stk_q[SW-3:0], din_i};
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            stk_q <= {2'b00, stk_q[SW-1:2]};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign dout_o  = stk_q[1:0];
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_PER = 8,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PER-1:0] per_req_i,
    input  logic               ext_irq_n_i,
    input  logic               nmi_n_i,
    input  logic               boundary_i,
    input  logic               rti_i,
    input  logic               sw_we_i,
    input  logic               sw_i_i,
    input  logic               sw_x_i,
    input  logic               cfg_we_i,
    input  logic               cfg_addr_i,
    input  logic [7:0]         cfg_data_i,
    output logic               take_o,
    output logic [7:0]         vec_o,
    output logic               mask_i_o,
    output logic               mask_x_o
);

    irqc_state_e state_q, state_d;

    logic       i_q, x_q;
    logic [7:0] vec_q;
    logic [7:0] promo_q;
    logic [1:0] ctl_q;

    logic       ext_req, nmi_req;
    logic       hit, nmi_sel, ext_sel;
    logic [7:0] arb_vec;
    logic       stk_full, stk_empty;
    logic [1:0] stk_dout;
    logic       in_run, accept, rti_act;

    assign nmi_req = ~nmi_n_i & ~x_q;
    assign in_run  = (state_q == ST_RUN);
    assign accept  = in_run & boundary_i & ~rti_i & hit & ~stk_full;
    assign rti_act = in_run & rti_i & ~stk_empty;

    irqc_pin_cond u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n_i     (ext_irq_n_i),
        .edge_mode_i (ctl_q[0]),
        .enable_i    (ctl_q[1]),
        .ack_i       (accept & ext_sel),
        .req_o       (ext_req)
    );

    irqc_arbiter #(.NUM_PER(NUM_PER)) u_arb (
        .nmi_req_i (nmi_req),
        .ext_req_i (ext_req),
        .per_req_i (per_req_i),
        .mask_ok_i (~i_q),
        .promo_i   (promo_q),
        .hit_o     (hit),
        .nmi_sel_o (nmi_sel),
        .ext_sel_o (ext_sel),
        .vec_o     (arb_vec)
    );

    irqc_mask_stack #(.DEPTH(DEPTH)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (accept),
        .pop_i   (rti_act),
        .din_i   ({i_q, x_q}),
        .dout_o  (stk_dout),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    state_d = ST_ACK;
                end else if (rti_act) begin
                    state_d = ST_RESTORE;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_ACK:     state_d = ST_RUN;
            ST_RESTORE: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // mask bits, vector and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q     <= 1'b1;
            x_q     <= 1'b1;
            vec_q   <= 8'h00;
            promo_q <= VEC_EXT;
            ctl_q   <= 2'b00;
        end else begin
            if (accept) begin
                i_q   <= 1'b1;
                vec_q <= arb_vec;
                if (nmi_sel) begin
                    x_q <= 1'b1;
                end
            end else if (rti_act) begin
                {i_q, x_q} <= stk_dout;
            end else if (in_run && sw_we_i) begin
                i_q <= sw_i_i;
                x_q <= x_q & sw_x_i;
            end
            if (cfg_we_i) begin
                if (cfg_addr_i) begin
                    ctl_q <= cfg_data_i[1:0];
                end else begin
                    promo_q <= cfg_data_i;
                end
            end
        end
    end

    // outputs
    always_comb begin
        take_o   = (state_q == ST_ACK);
        vec_o    = vec_q;
        mask_i_o = i_q;
        mask_x_o = x_q;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       boundary_i,
    input logic       rti_i,
    input logic       take_o,
    input logic [7:0] vec_o,
    input logic       mask_i_o,
    input logic       mask_x_o
);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_take_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(boundary_i) && !$past(rti_i)));

    p_entry_sets_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> mask_i_o);

    p_nmi_sets_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_NMI) |-> (mask_i_o && mask_x_o));

    p_maskable_needs_i_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o != VEC_NMI) |-> !$past(mask_i_o));

    p_x_rise_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_x_o) |-> ((take_o && vec_o == VEC_NMI) || $past(rti_i)));

    p_vec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(vec_o));

endmodule

bind irq_prio_ctrl irqc_checker u_irqc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .rti_i      (rti_i),
    .take_o     (take_o),
    .vec_o      (vec_o),
    .mask_i_o   (mask_i_o),
    .mask_x_o   (mask_x_o)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    localparam int NP    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] per_req = '0;
    logic          ext_n = 1'b1, nmi_n = 1'b1;
    logic          boundary = 1'b0, rti = 1'b0;
    logic          sw_we = 1'b0, sw_i = 1'b0, sw_x = 1'b0;
    logic          cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [7:0]    cfg_data = '0;
    logic          take, mask_i, mask_x;
    logic [7:0]    vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.NUM_PER(NP), .DEPTH(DEPTH)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .per_req_i(per_req), .ext_irq_n_i(ext_n),
        .nmi_n_i(nmi_n), .boundary_i(boundary), .rti_i(rti), .sw_we_i(sw_we),
        .sw_i_i(sw_i), .sw_x_i(sw_x), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_data_i(cfg_data), .take_o(take), .vec_o(vec),
        .mask_i_o(mask_i), .mask_x_o(mask_x)
    );

    // ---------------- behavioural reference model ----------------
    int         m_st;          // 0 running, 1 acknowledging, 2 restoring
    logic       m_i, m_x, m_prev, m_latch;
    logic [7:0] m_vec, m_promo;
    logic [1:0] m_ctl;
    logic [1:0] m_stk[$];
    logic [8:0] m_win;
    logic       m_acc, m_ret, m_ext;

    function automatic logic [8:0] m_pick(input logic nmi_p, input logic ext_p,
                                          input logic [NP-1:0] per, input logic ib,
                                          input logic [7:0] promo);
        if (nmi_p) return {1'b1, 8'hF4};
        if (ib) return 9'd0;
        if (ext_p && promo == 8'hF2) return {1'b1, 8'hF2};
        for (int k = 0; k < NP; k++)
            if (per[k] && promo == 8'(240 - 2 * k)) return {1'b1, 8'(240 - 2 * k)};
        if (ext_p) return {1'b1, 8'hF2};
        for (int k = 0; k < NP; k++)
            if (per[k]) return {1'b1, 8'(240 - 2 * k)};
        return 9'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_i = 1; m_x = 1; m_prev = 1; m_latch = 0;
            m_vec = 0; m_promo = 8'hF2; m_ctl = 0;
            m_stk.delete();
        end else begin
            m_ext = m_ctl[1] && (m_ctl[0] ? m_latch : !ext_n);
            m_win = m_pick(!nmi_n && !m_x, m_ext, per_req, m_i, m_promo);
            m_ret = (m_st == 0) && rti && (m_stk.size() > 0);
            m_acc = (m_st == 0) && boundary && !rti && m_win[8] && (m_stk.size() < DEPTH);
            if (m_ctl[0] && m_prev && !ext_n) m_latch = 1;
            else if (m_acc && m_win[7:0] == 8'hF2) m_latch = 0;
            m_prev = ext_n;
            if (m_acc) begin
                m_stk.push_back({m_i, m_x});
                m_vec = m_win[7:0];
                m_i = 1;
                if (m_win[7:0] == 8'hF4) m_x = 1;
            end else if (m_ret) begin
                {m_i, m_x} = m_stk.pop_back();
            end else if (m_st == 0 && sw_we) begin
                m_i = sw_i;
                m_x = m_x & sw_x;
            end
            if (cfg_we) begin
                if (cfg_addr) m_ctl = cfg_data[1:0];
                else m_promo = cfg_data;
            end
            m_st = m_acc ? 1 : (m_ret ? 2 : 0);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare the model with the design on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 take vs model", {7'd0, take}, {7'd0, m_st == 1});
            chk("R2 vector vs model", vec, m_vec);
            chk("R8 mask I vs model", {7'd0, mask_i}, {7'd0, m_i});
            chk("R7 mask X vs model", {7'd0, mask_x}, {7'd0, m_x});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobe();
        boundary = 1; tick(); boundary = 0;
    endtask

    task automatic do_ret();
        rti = 1; tick(); rti = 0; tick();
    endtask

    task automatic swm(input logic ni, input logic nx);
        sw_we = 1; sw_i = ni; sw_x = nx; tick(); sw_we = 0;
    endtask

    task automatic cfg(input logic a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_data = d; tick(); cfg_we = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 take", {7'd0, take}, 8'd0);
        chk("R1 vec", vec, 8'h00);
        chk("R1 I", {7'd0, mask_i}, 8'd1);
        chk("R1 X", {7'd0, mask_x}, 8'd1);

        // R2 fixed order, R8 entry, R9 restore, R11 still pending
        swm(0, 1);
        per_req = 8'b0000_1010;
        tick();
        strobe();
        chk("R2 higher identifier wins", vec, 8'hEE);
        chk("R8 take pulse", {7'd0, take}, 8'd1);
        chk("R8 I set on entry", {7'd0, mask_i}, 8'd1);
        tick();
        chk("R8 take lasts one cycle", {7'd0, take}, 8'd0);
        do_ret();
        chk("R9 I restored", {7'd0, mask_i}, 8'd0);
        strobe();
        chk("R11 pending serviced after return", vec, 8'hEE);
        tick(); do_ret();

        // R3 promotion
        cfg(0, 8'hEA);
        strobe();
        chk("R3 promoted source first", vec, 8'hEA);
        tick(); do_ret();
        cfg(0, 8'h13);
        strobe();
        chk("R3 unmatched promotion keeps order", vec, 8'hEE);
        tick(); do_ret();
        per_req = '0;
        cfg(0, 8'hF2);

        // R6 I blocks maskable
        per_req = 8'h01;
        swm(1, 1);
        strobe();
        chk("R6 maskable blocked by I", {7'd0, take}, 8'd0);
        per_req = '0;

        // R7 X blocks non-maskable, clear only
        nmi_n = 0;
        tick();
        strobe();
        chk("R7 non-maskable blocked by X", {7'd0, take}, 8'd0);
        swm(1, 0);
        chk("R7 X cleared by software", {7'd0, mask_x}, 8'd0);
        strobe();
        chk("R6 non-maskable ignores I", vec, 8'hF4);
        chk("R8 non-maskable sets X", {7'd0, mask_x}, 8'd1);
        nmi_n = 1;
        tick();
        do_ret();
        chk("R9 X restored", {7'd0, mask_x}, 8'd0);
        chk("R9 I restored to one", {7'd0, mask_i}, 8'd1);
        swm(1, 1);
        chk("R7 X cannot be set", {7'd0, mask_x}, 8'd0);

        // R4 level mode
        swm(0, 0);
        cfg(1, 8'h02);
        ext_n = 0;
        tick();
        strobe();
        chk("R4 level request", vec, 8'hF2);
        tick(); do_ret();
        strobe();
        chk("R4 level persists", {7'd0, take}, 8'd1);
        tick(); do_ret();
        ext_n = 1;
        tick();
        strobe();
        chk("R4 released pin idle", {7'd0, take}, 8'd0);
        cfg(1, 8'h00);
        ext_n = 0;
        tick();
        strobe();
        chk("R4 disabled pin ignored", {7'd0, take}, 8'd0);
        ext_n = 1;
        tick();

        // R5 edge mode
        cfg(1, 8'h03);
        ext_n = 0; tick();
        ext_n = 1; tick();
        strobe();
        chk("R5 edge latched", vec, 8'hF2);
        tick(); do_ret();
        strobe();
        chk("R5 latch cleared by acceptance", {7'd0, take}, 8'd0);
        cfg(1, 8'h00);

        // R10 strobe in ACK and with return ignored
        per_req = 8'h01;
        boundary = 1; tick();
        chk("R10 accepted", {7'd0, take}, 8'd1);
        tick(); boundary = 0;
        chk("R10 strobe in ACK ignored", {7'd0, take}, 8'd0);
        tick();
        do_ret();
        rti = 1; boundary = 1; tick(); rti = 0; boundary = 0;
        chk("R10 strobe with return ignored", {7'd0, take}, 8'd0);

        // R12 stack depth
        for (int n = 0; n < DEPTH; n++) begin
            strobe();
            chk("R12 nested entry", vec, 8'hF0);
            tick();
            swm(0, 0);
        end
        strobe();
        chk("R12 full stack blocks", {7'd0, take}, 8'd0);
        for (int n = 0; n < DEPTH; n++) do_ret();
        chk("R9 unwound I", {7'd0, mask_i}, 8'd0);
        per_req = '0;
        swm(1, 0);
        do_ret();
        chk("R12 empty return ignored", {7'd0, mask_i}, 8'd1);

        // random phase checked against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 7) == 0) per_req = NP'($urandom);
            ext_n    = ($urandom_range(0, 3) != 0);
            nmi_n    = ($urandom_range(0, 15) != 0);
            boundary = ($urandom_range(0, 2) == 0);
            rti      = ($urandom_range(0, 4) == 0);
            sw_we    = ($urandom_range(0, 7) == 0);
            sw_i     = 1'($urandom);
            sw_x     = ($urandom_range(0, 15) != 0);
            cfg_we   = ($urandom_range(0, 15) == 0);
            cfg_addr = 1'($urandom);
            cfg_data = ($urandom_range(0, 1) == 0) ? 8'(240 - 2 * $urandom_range(0, NP - 1))
                                                   : 8'($urandom);
            tick();
        end
        boundary = 0; rti = 0; sw_we = 0; cfg_we = 0;
        tick();
        finish_run();
    end

endmodule